// File: doc/BRIEF.md
# Power Manager Configuration Register Bank

This block is the register bank that sits between a fast bus clock and a slow always-on power controller. Software writes a control word, a wakeup source mask and a reset source mask in the fast domain. The control word holds a low-power hint and five per-domain clock and power options. None of these values reaches the slow domain until software issues an explicit sync command.

The sync command is carried across the boundary by a toggle handshake. Its busy bit reads 1 until the slow domain has captured the new values. Each source mask has its own write-enable that software can clear once, which freezes the mask until reset. The control write-enable clears by itself when the low-power hint is set and the processor waits for an interrupt, and it returns when the system is active again.

The bank also shows the currently asserted, already-enabled wake and reset requests as read-only status. It keeps a sticky wake-info record that software can clear and whose capture can be disabled.

Top module: `pmcfg_regbank`

## Requirements
- R1: After reset the control word, both masks, the wake-info record, the capture-disable bit, the sync busy bit and the three slow-domain outputs are 0, and all three write-enable bits read 1.
- R2: The control word (word 0) is 6 bits wide: bit 0 is the low-power hint; bits 1 to 5 are, in order, core clock kept in low power, IO clock kept in low power, USB clock kept in low power, USB clock kept in active power, and main domain kept powered in low power. `slow_ctrl_o` uses the same bit layout. Upper bits read 0.
- R3: Writes to the control word and the masks do not change `slow_ctrl_o`, `slow_wake_en_o` or `slow_rst_en_o`. The outputs take the fast-domain values only after a 1 is written to bit 0 of the sync word (word 6), and they hold them until the next sync.
- R4: Sync bit 0 reads 1 from the cycle after the sync write until the slow domain acknowledges, then 0. While it reads 1, writes to the control word and both masks are ignored, and a further sync write is ignored.
- R5: The wakeup mask (word 2) is bits 5:0 and the reset mask (word 4) is bits 1:0. Their upper bits read 0.
- R6: Writing 0 to bit 0 of a mask's write-enable word (word 3 for wakeup, word 5 for reset) locks that mask. Later writes to a locked mask are ignored, and writing 1 to the write-enable does not unlock it.
- R7: The control write-enable (word 1, bit 0, read-only) clears in the cycle after the hint is 1 while `cpu_wfi_i` is high, and sets again after `sys_active_i`. While it is 0, control writes are ignored. `cpu_wfi_i` with the hint at 0 leaves it at 1.
- R8: Wake status (word 7, bits 5:0) and reset status (word 8, bits 1:0) show the raw requests ANDed with the slow-domain masks, carried back into the fast domain.
- R9: The wake-info word (word 9) has the wake sources in bits 5:0, fall-through in bit 6 and abort in bit 7. A `rec_valid_i` pulse ORs in the current wake status and the two flags. Writing a 1 to a bit clears it, so writing all ones clears the record.
- R10: While the capture-disable bit (word 10, bit 0) is 1, `rec_valid_i` adds nothing to the wake-info word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Bus clock |
| rst_fast_ni | input | 1 | Synchronous active-low reset, fast domain |
| clk_slow_i | input | 1 | Always-on slow clock |
| rst_slow_ni | input | 1 | Synchronous active-low reset, slow domain |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| cpu_wfi_i | input | 1 | Processor waiting for interrupt |
| sys_active_i | input | 1 | System back in active power state |
| rec_valid_i | input | 1 | Wake event to record |
| rec_fall_i | input | 1 | Event was a fall-through |
| rec_abort_i | input | 1 | Event was an abort |
| wake_req_i | input | 6 | Raw wakeup requests, slow domain |
| rst_req_i | input | 2 | Raw reset requests, slow domain |
| slow_ctrl_o | output | 6 | Control word applied in the slow domain |
| slow_wake_en_o | output | 6 | Wakeup mask applied in the slow domain |
| slow_rst_en_o | output | 2 | Reset mask applied in the slow domain |

## Verification
A wrong handshake state shows at the ports in two ways: the sync bit never falls, or the slow outputs differ from the readback once it does, within a few slow cycles of the sync write. A wrong lock state shows on the very next readback, as a mask or control word that changed when it should have held, or one that held when it should have changed. A wrong status or record path shows as a wake or reset status word, or a wake-info value, that differs from the masked requests a few cycles after the requests settle.

// File: rtl/pmcfg_pkg.sv
// Package: shared sizes and register word indices of the power manager
// configuration bank. Assumes a word-indexed bus with a 4-bit index.
package pmcfg_pkg;
    localparam int ADDR_W   = 4;
    localparam int DOM_OPTS = 5;
    localparam int CTRL_W   = 1 + DOM_OPTS;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL_WE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_WMASK    = 4'd2;
    localparam logic [ADDR_W-1:0] A_WMASK_WE = 4'd3;
    localparam logic [ADDR_W-1:0] A_RMASK    = 4'd4;
    localparam logic [ADDR_W-1:0] A_RMASK_WE = 4'd5;
    localparam logic [ADDR_W-1:0] A_SYNC     = 4'd6;
    localparam logic [ADDR_W-1:0] A_WSTAT    = 4'd7;
    localparam logic [ADDR_W-1:0] A_RSTAT    = 4'd8;
    localparam logic [ADDR_W-1:0] A_WINFO    = 4'd9;
    localparam logic [ADDR_W-1:0] A_WINFO_DIS = 4'd10;
endpackage

// File: rtl/pmcfg_sync2.sv
// Module: two-flop synchronizer for a bus of independent bits.
// Assumes each bit may change at any time relative to clk_i and that a
// two-cycle latency is acceptable to every user.
module pmcfg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages in the destination clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/pmcfg_cfg_handshake.sv
// Module: toggle handshake that moves one "capture now" event from the
// fast domain to the slow domain and reports completion back.
// Assumes start_i is ignored by the caller while busy_o is 1, and that the
// data being captured is held stable while busy_o is 1.
module pmcfg_cfg_handshake (
    input  logic clk_fast_i,
    input  logic rst_fast_ni,
    input  logic clk_slow_i,
    input  logic rst_slow_ni,
    input  logic start_i,
    output logic busy_o,
    output logic capture_o
);
    logic req_tgl_q;
    logic req_slow;
    logic seen_q;
    logic ack_fast;

    // Fast side: flip the request toggle for each accepted start.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_fast_ni) req_tgl_q <= 1'b0;
        else if (start_i) req_tgl_q <= ~req_tgl_q;
    end

    pmcfg_sync2 #(.W(1)) u_req_sync (
        .clk_i (clk_slow_i),
        .rst_ni(rst_slow_ni),
        .d_i   (req_tgl_q),
        .q_o   (req_slow)
    );

    // Slow side: remember the last request level handled; it is also the ack.
    always_ff @(posedge clk_slow_i) begin
        if (!rst_slow_ni) seen_q <= 1'b0;
        else              seen_q <= req_slow;
    end

    assign capture_o = req_slow ^ seen_q;

    pmcfg_sync2 #(.W(1)) u_ack_sync (
        .clk_i (clk_fast_i),
        .rst_ni(rst_fast_ni),
        .d_i   (seen_q),
        .q_o   (ack_fast)
    );

    assign busy_o = req_tgl_q ^ ack_fast;
endmodule

// File: rtl/pmcfg_src_mask.sv
// Module: one lockable source mask with its own write-enable bit.
// Assumes hold_i is high while a clock-crossing transfer reads the mask.
module pmcfg_src_mask #(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_mask_i,
    input  logic         wr_lock_i,
    input  logic [W-1:0] wdata_i,
    input  logic         lock_bit_i,
    input  logic         hold_i,
    output logic [W-1:0] mask_o,
    output logic         open_o
);
    // Mask register: written only while open and not frozen by a transfer.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) mask_o <= '0;
        else if (wr_mask_i && open_o && !hold_i) mask_o <= wdata_i;
    end

    // Write-enable: only ever cleared, by writing 0; sticky until reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) open_o <= 1'b1;
        else if (wr_lock_i && !lock_bit_i) open_o <= 1'b0;
    end
endmodule

// File: rtl/pmcfg_regbank.sv
// Module: power manager configuration register bank (top).
// Holds the control word, two lockable source masks, live status and a
// wake-info record in the fast domain, and applies configuration in the
// slow domain only on an explicit sync. Assumes raw requests are in the
// slow domain and recording/lock inputs are in the fast domain.
module pmcfg_regbank
    import pmcfg_pkg::*;
#(
    parameter int WAKE_SRCS = 6,
    parameter int RST_SRCS  = 2,
    parameter int DW        = 32
) (
    input  logic                 clk_fast_i,
    input  logic                 rst_fast_ni,
    input  logic                 clk_slow_i,
    input  logic                 rst_slow_ni,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DW-1:0]        bus_wdata_i,
    output logic [DW-1:0]        bus_rdata_o,
    input  logic                 cpu_wfi_i,
    input  logic                 sys_active_i,
    input  logic                 rec_valid_i,
    input  logic                 rec_fall_i,
    input  logic                 rec_abort_i,
    input  logic [WAKE_SRCS-1:0] wake_req_i,
    input  logic [RST_SRCS-1:0]  rst_req_i,
    output logic [CTRL_W-1:0]    slow_ctrl_o,
    output logic [WAKE_SRCS-1:0] slow_wake_en_o,
    output logic [RST_SRCS-1:0]  slow_rst_en_o
);
    localparam int INFO_W    = WAKE_SRCS + 2;
    localparam int FALL_BIT  = WAKE_SRCS;
    localparam int ABORT_BIT = WAKE_SRCS + 1;

    logic [CTRL_W-1:0]    ctrl_q;
    logic                 ctrl_open_q;
    logic [WAKE_SRCS-1:0] wake_mask;
    logic                 wake_open;
    logic [RST_SRCS-1:0]  rst_mask;
    logic                 rst_open;
    logic                 cfg_busy;
    logic                 cfg_capture;
    logic                 sync_start;
    logic [WAKE_SRCS-1:0] wake_hit_q;
    logic [RST_SRCS-1:0]  rst_hit_q;
    logic [WAKE_SRCS-1:0] wake_stat;
    logic [RST_SRCS-1:0]  rst_stat;
    logic [INFO_W-1:0]    info_q;
    logic [INFO_W-1:0]    info_set;
    logic [INFO_W-1:0]    info_clr;
    logic                 info_dis_q;
    logic                 unused_wdata;

    function automatic logic wr_at(input logic [ADDR_W-1:0] a);
        return bus_we_i && (bus_addr_i == a);
    endfunction

    assign unused_wdata = ^bus_wdata_i[DW-1:INFO_W];

    // Control word: writable while its write-enable is set and no sync runs.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_fast_ni) ctrl_q <= '0;
        else if (wr_at(A_CTRL) && ctrl_open_q && !cfg_busy)
            ctrl_q <= bus_wdata_i[CTRL_W-1:0];
    end

    // Control write-enable: drops on hinted wait-for-interrupt, returns on active.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_fast_ni) ctrl_open_q <= 1'b1;
        else if (ctrl_q[0] && cpu_wfi_i) ctrl_open_q <= 1'b0;
        else if (sys_active_i) ctrl_open_q <= 1'b1;
    end

    pmcfg_src_mask #(.W(WAKE_SRCS)) u_wake_mask (
        .clk_i     (clk_fast_i),
        .rst_ni    (rst_fast_ni),
        .wr_mask_i (wr_at(A_WMASK)),
        .wr_lock_i (wr_at(A_WMASK_WE)),
        .wdata_i   (bus_wdata_i[WAKE_SRCS-1:0]),
        .lock_bit_i(bus_wdata_i[0]),
        .hold_i    (cfg_busy),
        .mask_o    (wake_mask),
        .open_o    (wake_open)
    );

    pmcfg_src_mask #(.W(RST_SRCS)) u_rst_mask (
        .clk_i     (clk_fast_i),
        .rst_ni    (rst_fast_ni),
        .wr_mask_i (wr_at(A_RMASK)),
        .wr_lock_i (wr_at(A_RMASK_WE)),
        .wdata_i   (bus_wdata_i[RST_SRCS-1:0]),
        .lock_bit_i(bus_wdata_i[0]),
        .hold_i    (cfg_busy),
        .mask_o    (rst_mask),
        .open_o    (rst_open)
    );

    assign sync_start = wr_at(A_SYNC) && bus_wdata_i[0] && !cfg_busy;

    pmcfg_cfg_handshake u_hs (
        .clk_fast_i (clk_fast_i),
        .rst_fast_ni(rst_fast_ni),
        .clk_slow_i (clk_slow_i),
        .rst_slow_ni(rst_slow_ni),
        .start_i    (sync_start),
        .busy_o     (cfg_busy),
        .capture_o  (cfg_capture)
    );

    // Slow-domain shadow: take the frozen fast registers on each capture.
    always_ff @(posedge clk_slow_i) begin
        if (!rst_slow_ni) begin
            slow_ctrl_o    <= '0;
            slow_wake_en_o <= '0;
            slow_rst_en_o  <= '0;
        end else if (cfg_capture) begin
            slow_ctrl_o    <= ctrl_q;
            slow_wake_en_o <= wake_mask;
            slow_rst_en_o  <= rst_mask;
        end
    end

    // Slow-domain enabled requests, registered before crossing back.
    always_ff @(posedge clk_slow_i) begin
        if (!rst_slow_ni) begin
            wake_hit_q <= '0;
            rst_hit_q  <= '0;
        end else begin
            wake_hit_q <= wake_req_i & slow_wake_en_o;
            rst_hit_q  <= rst_req_i & slow_rst_en_o;
        end
    end

    pmcfg_sync2 #(.W(WAKE_SRCS)) u_wstat_sync (
        .clk_i (clk_fast_i),
        .rst_ni(rst_fast_ni),
        .d_i   (wake_hit_q),
        .q_o   (wake_stat)
    );

    pmcfg_sync2 #(.W(RST_SRCS)) u_rstat_sync (
        .clk_i (clk_fast_i),
        .rst_ni(rst_fast_ni),
        .d_i   (rst_hit_q),
        .q_o   (rst_stat)
    );

    // Wake-info set and clear terms; a recorded bit beats a same-cycle clear.
    always_comb begin
        info_set = '0;
        if (rec_valid_i && !info_dis_q) begin
            info_set[WAKE_SRCS-1:0] = wake_stat;
            info_set[FALL_BIT]      = rec_fall_i;
            info_set[ABORT_BIT]     = rec_abort_i;
        end
        info_clr = wr_at(A_WINFO) ? bus_wdata_i[INFO_W-1:0] : '0;
    end

    // Wake-info record register.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_fast_ni) info_q <= '0;
        else              info_q <= (info_q & ~info_clr) | info_set;
    end

    // Capture-disable bit.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_fast_ni) info_dis_q <= 1'b0;
        else if (wr_at(A_WINFO_DIS)) info_dis_q <= bus_wdata_i[0];
    end

    // Read mux: zero-extended register contents for the addressed word.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL:      bus_rdata_o[CTRL_W-1:0]    = ctrl_q;
            A_CTRL_WE:   bus_rdata_o[0]             = ctrl_open_q;
            A_WMASK:     bus_rdata_o[WAKE_SRCS-1:0] = wake_mask;
            A_WMASK_WE:  bus_rdata_o[0]             = wake_open;
            A_RMASK:     bus_rdata_o[RST_SRCS-1:0]  = rst_mask;
            A_RMASK_WE:  bus_rdata_o[0]             = rst_open;
            A_SYNC:      bus_rdata_o[0]             = cfg_busy;
            A_WSTAT:     bus_rdata_o[WAKE_SRCS-1:0] = wake_stat;
            A_RSTAT:     bus_rdata_o[RST_SRCS-1:0]  = rst_stat;
            A_WINFO:     bus_rdata_o[INFO_W-1:0]    = info_q;
            A_WINFO_DIS: bus_rdata_o[0]             = info_dis_q;
            default:     bus_rdata_o                = '0;
        endcase
    end
endmodule

// File: rtl/pmcfg_regbank_chk.sv
// Module: property checker for the configuration bank, fast domain.
// Assumes it is bound into pmcfg_regbank and sees its internal registers.
module pmcfg_regbank_chk #(
    parameter int CTRL_W = 6,
    parameter int WAKE_W = 6,
    parameter int RST_W  = 2,
    parameter int INFO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              wfi,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              ctrl_open,
    input logic [WAKE_W-1:0] wake_mask,
    input logic              wake_open,
    input logic [RST_W-1:0]  rst_mask,
    input logic              rst_open,
    input logic [INFO_W-1:0] info_q,
    input logic              info_dis
);
    // R6
    wake_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_open |=> !wake_open);
    // R6
    rst_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_open |=> !rst_open);
    // R6
    wake_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_open |=> $stable(wake_mask));
    // R6
    rst_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_open |=> $stable(rst_mask));
    // R7
    ctrl_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_open |=> $stable(ctrl_q));
    // R7
    ctrl_lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && wfi) |=> !ctrl_open);
    // R4
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ctrl_q) && $stable(wake_mask) && $stable(rst_mask)));
    // R10
    capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        info_dis |=> ((info_q & ~$past(info_q)) == '0));
endmodule

bind pmcfg_regbank pmcfg_regbank_chk #(
    .CTRL_W(pmcfg_pkg::CTRL_W),
    .WAKE_W(WAKE_SRCS),
    .RST_W (RST_SRCS),
    .INFO_W(WAKE_SRCS + 2)
) u_chk (
    .clk      (clk_fast_i),
    .rst_n    (rst_fast_ni),
    .busy     (cfg_busy),
    .wfi      (cpu_wfi_i),
    .ctrl_q   (ctrl_q),
    .ctrl_open(ctrl_open_q),
    .wake_mask(wake_mask),
    .wake_open(wake_open),
    .rst_mask (rst_mask),
    .rst_open (rst_open),
    .info_q   (info_q),
    .info_dis (info_dis_q)
);

// File: tb/pmcfg_regbank_tb.sv
// Bench: vector table of write/readback pairs, then directed tests for
// reset, sync crossing, locks, status and wake-info recording.
module pmcfg_regbank_tb;
    logic        clk_fast = 1'b0;
    logic        clk_slow = 1'b0;
    logic        rst_fast_n = 1'b0;
    logic        rst_slow_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wfi = 1'b0;
    logic        active = 1'b0;
    logic        rec_v = 1'b0;
    logic        rec_f = 1'b0;
    logic        rec_a = 1'b0;
    logic [5:0]  wreq = '0;
    logic [1:0]  rreq = '0;
    logic [5:0]  s_ctrl;
    logic [5:0]  s_wen;
    logic [1:0]  s_ren;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk_fast = ~clk_fast;
    always #35 clk_slow = ~clk_slow;

    pmcfg_regbank u_dut (
        .clk_fast_i(clk_fast), .rst_fast_ni(rst_fast_n),
        .clk_slow_i(clk_slow), .rst_slow_ni(rst_slow_n),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cpu_wfi_i(wfi), .sys_active_i(active),
        .rec_valid_i(rec_v), .rec_fall_i(rec_f), .rec_abort_i(rec_a),
        .wake_req_i(wreq), .rst_req_i(rreq),
        .slow_ctrl_o(s_ctrl), .slow_wake_en_o(s_wen), .slow_rst_en_o(s_ren)
    );

    // {word index, write data, expected readback}
    localparam logic [67:0] VEC [10] = '{
        {4'd0,  32'hFFFF_FFFF, 32'h0000_003F},   // R2 width
        {4'd0,  32'h0000_0014, 32'h0000_0014},   // R2
        {4'd2,  32'hFFFF_FFFF, 32'h0000_003F},   // R5
        {4'd2,  32'h0000_002A, 32'h0000_002A},   // R5
        {4'd4,  32'h0000_00FF, 32'h0000_0003},   // R5
        {4'd4,  32'h0000_0001, 32'h0000_0001},   // R5
        {4'd10, 32'h0000_0001, 32'h0000_0001},   // R10
        {4'd10, 32'h0000_0000, 32'h0000_0000},   // R10
        {4'd1,  32'h0000_0000, 32'h0000_0001},   // R7 read-only
        {4'd7,  32'h0000_003F, 32'h0000_0000}    // R8 read-only
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk_fast);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk_fast);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk_fast);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk_fast);
        s = 1'b1;
        @(negedge clk_fast);
        s = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        rd(4'd6, v);
        while (v[0] && n < 200) begin
            rd(4'd6, v);
            n++;
        end
        check(req, {31'd0, v[0]}, 32'd0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (40) @(negedge clk_fast);
        rst_fast_n = 1'b1;
        rst_slow_n = 1'b1;
        repeat (2) @(negedge clk_fast);

        // R1 reset state
        rd_chk("R1 ctrl", 4'd0, 32'h0);
        rd_chk("R1 ctrl_we", 4'd1, 32'h1);
        rd_chk("R1 wmask_we", 4'd3, 32'h1);
        rd_chk("R1 rmask_we", 4'd5, 32'h1);
        rd_chk("R1 sync", 4'd6, 32'h0);
        rd_chk("R1 winfo", 4'd9, 32'h0);
        check("R1 slow outputs", {18'd0, s_ctrl, s_wen, s_ren}, 32'h0);

        // Table walk: write then read back
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            rd_chk("R2/R5/R7/R8/R10 vector", VEC[i][67:64], VEC[i][31:0]);
        end

        // R3: no sync yet, slow outputs unchanged
        repeat (20) @(negedge clk_fast);
        check("R3 no sync", {18'd0, s_ctrl, s_wen, s_ren}, 32'h0);

        // R4: sync busy and freeze
        wr(4'd6, 32'h1);
        rd_chk("R4 busy high", 4'd6, 32'h1);
        wr(4'd0, 32'h3);
        wr(4'd2, 32'h01);
        wait_idle("R4 busy clears");
        rd_chk("R4 ctrl frozen", 4'd0, 32'h14);
        rd_chk("R4 wmask frozen", 4'd2, 32'h2A);
        check("R3 slow ctrl", {26'd0, s_ctrl}, 32'h14);
        check("R3 slow wake en", {26'd0, s_wen}, 32'h2A);
        check("R3 slow rst en", {30'd0, s_ren}, 32'h1);

        // R8: masked status
        @(negedge clk_fast);
        wreq = 6'h3F; rreq = 2'b11;
        repeat (20) @(negedge clk_fast);
        rd_chk("R8 wake status", 4'd7, 32'h2A);
        rd_chk("R8 reset status", 4'd8, 32'h1);

        // R9 record and clear
        rec_f = 1'b1;
        pulse(rec_v);
        rec_f = 1'b0;
        rd_chk("R9 record fall", 4'd9, 32'h6A);
        wr(4'd9, 32'hFFFF_FFFF);
        rd_chk("R9 clear all", 4'd9, 32'h0);
        // R10 capture disabled
        wr(4'd10, 32'h1);
        rec_a = 1'b1;
        pulse(rec_v);
        rd_chk("R10 disabled", 4'd9, 32'h0);
        wr(4'd10, 32'h0);
        pulse(rec_v);
        rec_a = 1'b0;
        rd_chk("R9 record abort", 4'd9, 32'hAA);
        wr(4'd9, 32'h80);
        rd_chk("R9 partial clear", 4'd9, 32'h2A);

        // R6 locks
        wr(4'd3, 32'h0);
        wr(4'd2, 32'h3F);
        rd_chk("R6 wake locked", 4'd2, 32'h2A);
        wr(4'd3, 32'h1);
        rd_chk("R6 wake lock sticky", 4'd3, 32'h0);
        wr(4'd5, 32'h0);
        wr(4'd4, 32'h2);
        rd_chk("R6 reset locked", 4'd4, 32'h1);

        // R7 control lock
        pulse(wfi);
        rd_chk("R7 wfi without hint", 4'd1, 32'h1);
        wr(4'd0, 32'h15);
        pulse(wfi);
        rd_chk("R7 lock on hinted wfi", 4'd1, 32'h0);
        wr(4'd0, 32'h0);
        rd_chk("R7 ctrl locked", 4'd0, 32'h15);
        check("R3 slow ctrl held", {26'd0, s_ctrl}, 32'h14);
        pulse(active);
        rd_chk("R7 unlock on active", 4'd1, 32'h1);
        wr(4'd0, 32'h0);
        rd(4'd0, v);
        check("R7 ctrl writable", v, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule